// File: doc/BRIEF.md
# Host schedule run-stop controller

This block decides when a USB-style host controller may walk its transfer schedule. Software controls it through two bits of a command register: a run bit and a debug-enable bit. The block reports a halted flag in a status register. It keeps a millisecond frame timer, built as a prescaler, and an 11-bit frame number. When execution starts, the block decides whether to restart at the start of a frame or to resume at a saved descriptor pointer.

A transfer-descriptor engine works next to this block. The engine fetches descriptors only while `sched_go` is high. It reports each fetch, along with the pointer to the next descriptor, and it signals transaction busy and transaction done. With debug enabled, the block clears the run bit on every fetch. Each start therefore executes exactly one descriptor, and while halted the frame timer stays frozen so that the next start continues mid-frame. Fatal-error inputs clear the run bit at once.

Top module: `sched_runctl`

## Requirements
- R1: After reset the run and debug bits are 0, the halted bit is 1, and the frame timer and frame number are 0.
- R2: A command write takes the run bit from `cmd_wdata[0]` and the debug bit from `cmd_wdata[5]`. `cmd_q` reads back the run bit at bit 0 and the debug bit at bit 5, with all other bits 0. `sts_q[5]` is the halted bit, and all other status bits are 0.
- R3: The halted bit clears one cycle after the run bit reads 1. During the cycle in which the run bit reads 1 while halted, a start with debug off pulses `sof_start`, and `list_idx` equals the low 10 bits of the frame number.
- R4: If the run bit is cleared while a descriptor is in flight (fetched and not yet done), the halted bit stays 0 until `xact_done`. It reads 1 in the cycle after `xact_done`.
- R5: If the run bit is cleared with no transaction pending, the halted bit reads 1 two cycles after the write.
- R6: While halted with debug off, the frame timer is held at 0.
- R7: While not halted, the frame timer counts 0 to CYC_PER_FRAME-1. In its last count `sof_start` is 1. On wrapping, the frame number increments modulo 2^11.
- R8: While halted with debug on, the frame timer and frame number hold their values. The next start pulses `resume_start` instead of `sof_start` and presents the pointer from the last fetch on `resume_ptr`. The timer then continues from the held value.
- R9: With debug on, a descriptor fetch clears the run bit in the next cycle. The block halts after that descriptor's `xact_done`.
- R10: Either fatal-error input clears the run bit in the next cycle, even if a command write sets it in the same cycle.
- R11: Frame-number writes take effect only while the run bit is 0. While it is 1 they are ignored.
- R12: In debug mode, a fetch that coincides with a command write setting the run bit leaves the run bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command write data (bit 0 run, bit 5 debug) |
| cmd_q | output | 8 | Command register readback |
| sts_q | output | 8 | Status register (bit 5 halted) |
| fn_we | input | 1 | Frame-number write strobe |
| fn_wdata | input | FN_W | Frame-number write data |
| frnum | output | FN_W | Current frame number |
| list_idx | output | 10 | Frame-list entry selected by the frame number |
| tmr_q | output | TMR_W | Frame prescaler count |
| sched_go | output | 1 | Engine may fetch the next descriptor |
| sof_start | output | 1 | Start-of-frame pulse (restart or frame wrap) |
| resume_start | output | 1 | Debug resume pulse |
| resume_ptr | output | PTR_W | Saved descriptor pointer for resume |
| td_fetch | input | 1 | Engine fetched a descriptor |
| td_ptr | input | PTR_W | Pointer to the descriptor after the fetched one |
| xact_busy | input | 1 | Engine transaction in progress |
| xact_done | input | 1 | Engine transaction completed |
| err_consist | input | 1 | Fatal consistency-check failure |
| err_bus | input | 1 | Fatal system bus error |

## Verification
A sequencer stuck in the wrong state shows up at `sts_q[5]` and `sched_go` within one or two cycles of a run-bit change or a transaction end. The bench therefore samples halted in every cycle of each stop and drain. Faults in the prescaler or frame counter show up as a mismatch in `tmr_q`, `frnum` or `sof_start` in the very next cycle. The bench sweeps these values cycle by cycle across several frame wraps, including the 11-bit rollover. A lost saved pointer or a wrong freeze decision only becomes visible at the next debug start, so the bench restarts after every single step and compares the timer and `resume_ptr`.

// File: rtl/sched_runctl_pkg.sv
package sched_runctl_pkg;

    localparam int RUN_BIT  = 0;
    localparam int DBG_BIT  = 5;
    localparam int HALT_BIT = 5;
    localparam int LIST_W   = 10;

    typedef enum logic [1:0] {
        ST_HALTED   = 2'd0,
        ST_RUNNING  = 2'd1,
        ST_DRAINING = 2'd2
    } sched_state_e;

    typedef struct packed {
        logic dbg;
        logic run;
    } cmd_bits_t;

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic [7:0] pack_cmd(input cmd_bits_t c);
        logic [7:0] v;
        v = '0;
        v[RUN_BIT] = c.run;
        v[DBG_BIT] = c.dbg;
        return v;
    endfunction

endpackage

// File: rtl/sched_cmd_reg.sv
module sched_cmd_reg
    import sched_runctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      wr_run,
    input  logic      wr_dbg,
    input  logic      fetch,
    input  logic      fatal,
    output cmd_bits_t cmd
);

    cmd_bits_t cmd_n;

    always_comb begin
        cmd_n = cmd;
        if (wr_en) begin
            cmd_n.run = wr_run;
            cmd_n.dbg = wr_dbg;
        end
        // hardware clears win over a software set
        if (fatal || (cmd.dbg && fetch))
            cmd_n.run = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) cmd <= '0;
        else     cmd <= cmd_n;
    end

    AST_FATAL_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
        fatal |=> !cmd.run); // R10
    AST_STEP_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
        (cmd.dbg && fetch) |=> !cmd.run); // R9

endmodule

// File: rtl/sched_frame_timer.sv
module sched_frame_timer
    import sched_runctl_pkg::*;
#(
    parameter int CYC_PER_FRAME = 50000,
    parameter int FN_W          = 11,
    localparam int TMR_W        = cnt_width(CYC_PER_FRAME)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             counting,
    input  logic             dbg,
    input  logic             run,
    input  logic             fn_we,
    input  logic [FN_W-1:0]  fn_wdata,
    output logic [TMR_W-1:0] tmr,
    output logic [FN_W-1:0]  frnum,
    output logic             wrap
);

    localparam logic [TMR_W-1:0] LAST = TMR_W'(CYC_PER_FRAME - 1);

    assign wrap = counting && (tmr == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr   <= '0;
            frnum <= '0;
        end else begin
            if (counting) begin
                if (wrap) begin
                    tmr   <= '0;
                    frnum <= frnum + 1'b1;
                end else begin
                    tmr <= tmr + 1'b1;
                end
            end else if (!dbg) begin
                tmr <= '0;
            end
            if (fn_we && !run)
                frnum <= fn_wdata;
        end
    end

    AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        tmr <= LAST); // R7
    AST_FRNUM_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> frnum == $past(frnum)); // R11
    AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!counting && dbg) |=> $stable(tmr)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!counting && !dbg) |=> tmr == '0); // R6

endmodule

// File: rtl/sched_seq.sv
module sched_seq
    import sched_runctl_pkg::*;
#(
    parameter int PTR_W = 32
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             td_fetch,
    input  logic [PTR_W-1:0] td_ptr,
    input  logic             xact_busy,
    input  logic             xact_done,
    output logic             halted,
    output logic             counting,
    output logic             go,
    output logic             start_evt,
    output logic [PTR_W-1:0] saved_ptr
);

    sched_state_e state, state_n;
    logic         pend;
    logic         busy_any;

    assign busy_any  = pend || xact_busy || td_fetch;
    assign halted    = (state == ST_HALTED);
    assign counting  = !halted;
    assign go        = (state == ST_RUNNING) && run;
    assign start_evt = halted && run;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_HALTED:   if (run) state_n = ST_RUNNING;
            ST_RUNNING:  if (!run) state_n = busy_any ? ST_DRAINING : ST_HALTED;
            ST_DRAINING: if (xact_done || !busy_any) state_n = ST_HALTED;
            default:     state_n = ST_HALTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HALTED;
            pend      <= 1'b0;
            saved_ptr <= '0;
        end else begin
            state <= state_n;
            if (td_fetch) begin
                pend      <= 1'b1;
                saved_ptr <= td_ptr;
            end else if (xact_done) begin
                pend <= 1'b0;
            end
        end
    end

    AST_START_LEAVES_HALT: assert property (@(posedge clk) disable iff (rst)
        (halted && run) |=> !halted); // R3
    AST_NO_HALT_MIDXACT: assert property (@(posedge clk) disable iff (rst)
        (!halted && pend && !xact_done) |=> !halted); // R4
    AST_DONE_HALTS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAINING && xact_done && !run) |=> halted); // R4

endmodule

// File: rtl/sched_runctl.sv
module sched_runctl
    import sched_runctl_pkg::*;
#(
    parameter int CYC_PER_FRAME = 50000,
    parameter int FN_W          = 11,
    parameter int PTR_W         = 32,
    localparam int TMR_W        = cnt_width(CYC_PER_FRAME)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_wdata,
    output logic [7:0]        cmd_q,
    output logic [7:0]        sts_q,
    input  logic              fn_we,
    input  logic [FN_W-1:0]   fn_wdata,
    output logic [FN_W-1:0]   frnum,
    output logic [LIST_W-1:0] list_idx,
    output logic [TMR_W-1:0]  tmr_q,
    output logic              sched_go,
    output logic              sof_start,
    output logic              resume_start,
    output logic [PTR_W-1:0]  resume_ptr,
    input  logic              td_fetch,
    input  logic [PTR_W-1:0]  td_ptr,
    input  logic              xact_busy,
    input  logic              xact_done,
    input  logic              err_consist,
    input  logic              err_bus
);

    cmd_bits_t cmd;
    logic      halted, counting, start_evt, wrap;
    logic      unused_wbits;

    assign unused_wbits = ^{cmd_wdata[7:6], cmd_wdata[4:1]};

    sched_cmd_reg u_cmd (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cmd_we),
        .wr_run (cmd_wdata[RUN_BIT]),
        .wr_dbg (cmd_wdata[DBG_BIT]),
        .fetch  (td_fetch),
        .fatal  (err_consist || err_bus),
        .cmd    (cmd)
    );

    sched_seq #(.PTR_W(PTR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .run       (cmd.run),
        .td_fetch  (td_fetch),
        .td_ptr    (td_ptr),
        .xact_busy (xact_busy),
        .xact_done (xact_done),
        .halted    (halted),
        .counting  (counting),
        .go        (sched_go),
        .start_evt (start_evt),
        .saved_ptr (resume_ptr)
    );

    sched_frame_timer #(.CYC_PER_FRAME(CYC_PER_FRAME), .FN_W(FN_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .counting (counting),
        .dbg      (cmd.dbg),
        .run      (cmd.run),
        .fn_we    (fn_we),
        .fn_wdata (fn_wdata),
        .tmr      (tmr_q),
        .frnum    (frnum),
        .wrap     (wrap)
    );

    assign cmd_q        = pack_cmd(cmd);
    assign list_idx     = frnum[LIST_W-1:0];
    assign sof_start    = (start_evt && !cmd.dbg) || wrap;
    assign resume_start = start_evt && cmd.dbg;

    always_comb begin
        sts_q           = '0;
        sts_q[HALT_BIT] = halted;
    end

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(resume_start && sof_start)); // R8

endmodule

// File: tb/sched_runctl_test.sv
module sched_runctl_test;

    localparam int CYC = 8;
    localparam int FNW = 11;
    localparam int PW  = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_we = 1'b0;
    logic [7:0]    cmd_wdata = '0;
    logic [7:0]    cmd_q, sts_q;
    logic          fn_we = 1'b0;
    logic [FNW-1:0] fn_wdata = '0;
    logic [FNW-1:0] frnum;
    logic [9:0]    list_idx;
    logic [2:0]    tmr_q;
    logic          sched_go, sof_start, resume_start;
    logic [PW-1:0] resume_ptr;
    logic          td_fetch = 1'b0;
    logic [PW-1:0] td_ptr = '0;
    logic          xact_busy = 1'b0, xact_done = 1'b0;
    logic          err_consist = 1'b0, err_bus = 1'b0;

    int checks = 0;
    int fails  = 0;
    int t_hold, f_hold;

    always #10 clk = ~clk;

    sched_runctl #(.CYC_PER_FRAME(CYC), .FN_W(FNW), .PTR_W(PW)) uut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_q(cmd_q), .sts_q(sts_q), .fn_we(fn_we), .fn_wdata(fn_wdata),
        .frnum(frnum), .list_idx(list_idx), .tmr_q(tmr_q), .sched_go(sched_go),
        .sof_start(sof_start), .resume_start(resume_start), .resume_ptr(resume_ptr),
        .td_fetch(td_fetch), .td_ptr(td_ptr), .xact_busy(xact_busy),
        .xact_done(xact_done), .err_consist(err_consist), .err_bus(err_bus)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic wr_cmd(input logic [7:0] v);
        cmd_we = 1'b1; cmd_wdata = v;
        nxt();
        cmd_we = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) nxt();
        rst = 1'b0;
        nxt();
        // R1 reset state
        chk("R1 cmd", cmd_q, 0);
        chk("R1 halted", sts_q, 8'h20);
        chk("R1 tmr", tmr_q, 0);
        chk("R1 frnum", frnum, 0);

        // R11 write accepted while stopped
        fn_we = 1'b1; fn_wdata = 11'h7FD;
        nxt();
        fn_we = 1'b0;
        chk("R11 frnum load", frnum, 11'h7FD);

        // R2/R3 start with debug off
        wr_cmd(8'h01);
        chk("R2 cmd readback", cmd_q, 8'h01);
        chk("R3 still halted", sts_q, 8'h20);
        chk("R3 sof on start", sof_start, 1);
        chk("R3 list index", list_idx, 10'h3FD);
        nxt();
        chk("R3 halted cleared", sts_q, 0);

        // R7 sweep across frames and the 11-bit rollover; R11 write ignored
        for (int k = 0; k < 30; k++) begin
            chk("R7 tmr", tmr_q, k % CYC);
            chk("R7 frnum", frnum, (11'h7FD + k / CYC) & 11'h7FF);
            chk("R7 list", list_idx, ((11'h7FD + k / CYC) & 11'h3FF));
            chk("R7 sof", sof_start, (k % CYC == CYC - 1) ? 1 : 0);
            fn_we = (k == 10); fn_wdata = 11'h123;
            nxt();
        end
        fn_we = 1'b0;

        // R5 idle stop, R6 timer cleared
        wr_cmd(8'h00);
        chk("R5 not yet halted", sts_q, 0);
        nxt();
        chk("R5 halted", sts_q, 8'h20);
        for (int k = 0; k < 3; k++) begin
            nxt();
            chk("R6 tmr held zero", tmr_q, 0);
        end

        // R4 stop during an in-flight transaction
        wr_cmd(8'h01);
        nxt(); nxt();
        chk("R4 go", sched_go, 1);
        td_fetch = 1'b1; td_ptr = 16'h1111;
        nxt();
        td_fetch = 1'b0; xact_busy = 1'b1;
        wr_cmd(8'h00);
        for (int k = 0; k < 4; k++) begin
            chk("R4 no halt mid transaction", sts_q, 0);
            chk("R4 go low", sched_go, 0);
            nxt();
        end
        xact_done = 1'b1;
        nxt();
        xact_done = 1'b0; xact_busy = 1'b0;
        chk("R4 halted after done", sts_q, 8'h20);

        // R8/R9/R12 single step in debug mode
        wr_cmd(8'h20);
        chk("R2 dbg readback", cmd_q, 8'h20);
        wr_cmd(8'h21);
        chk("R8 resume pulse", resume_start, 1);
        chk("R8 no sof", sof_start, 0);
        chk("R8 resume ptr", resume_ptr, 16'h1111);
        nxt();
        chk("R9 go", sched_go, 1);
        nxt(); nxt();
        td_fetch = 1'b1; td_ptr = 16'h2222;
        cmd_we = 1'b1; cmd_wdata = 8'h21;
        nxt();
        td_fetch = 1'b0; cmd_we = 1'b0; xact_busy = 1'b1;
        chk("R12 run cleared by fetch", cmd_q, 8'h20);
        for (int k = 0; k < 3; k++) begin
            chk("R9 busy not halted", sts_q, 0);
            nxt();
        end
        xact_done = 1'b1;
        nxt();
        xact_done = 1'b0; xact_busy = 1'b0;
        chk("R9 halted after step", sts_q, 8'h20);
        t_hold = tmr_q; f_hold = frnum;
        for (int k = 0; k < 6; k++) begin
            nxt();
            chk("R8 tmr frozen", tmr_q, t_hold);
            chk("R8 frnum kept", frnum, f_hold);
        end
        wr_cmd(8'h21);
        chk("R8 resume pulse 2", resume_start, 1);
        chk("R8 resume ptr 2", resume_ptr, 16'h2222);
        nxt();
        chk("R8 tmr continues", tmr_q, t_hold);
        nxt();
        chk("R8 tmr advances", tmr_q, (t_hold + 1) % CYC);

        // R10 fatal errors
        err_consist = 1'b1;
        nxt();
        err_consist = 1'b0;
        chk("R10 consist clears run", cmd_q, 8'h20);
        nxt();
        chk("R10 halts", sts_q, 8'h20);
        wr_cmd(8'h00);
        cmd_we = 1'b1; cmd_wdata = 8'h01; err_bus = 1'b1;
        nxt();
        cmd_we = 1'b0; err_bus = 1'b0;
        chk("R10 bus beats write", cmd_q, 0);
        nxt();
        chk("R10 stays halted", sts_q, 8'h20);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule